// File: doc/BRIEF.md
# Board System-Controller Register Block

This block is the system controller of a development board, seen from software as a window of 32-bit registers. Most of the words it returns are fixed or come from strap inputs: build identifiers, memory-controller health, the clock-synthesiser settings, the set of enabled PCIe ports and the size and speed class of the DDR. The block only reports the state of those subsystems and does not drive them. The one active function is the soft-reset control word. A full-word write to it with the reset bit set produces a single-cycle system reset request.

Requests arrive on a valid/ready channel. `req_ready` rises in the first cycle after reset and then stays high, so a requester never waits. A request is accepted in any cycle where `req_valid` and `req_ready` are both high. Exactly one cycle later `rsp_valid` pulses with the read word. The response has no ready signal and cannot be held off, so the requester must take it in the cycle it appears. Only the low 16 address bits are decoded. Only 4-byte accesses take effect.

Top module: `board_sysctl`

## Requirements
- R1: After reset, `req_ready` is high from the first clock edge onward. Every accepted request, mapped or not, gives `rsp_valid` high for exactly the next cycle. Without an accepted request, `rsp_valid` is low.
- R2: An access whose `req_size` (the byte count) is not 4 returns zero data. If it is a write, it raises no reset request.
- R3: These offsets read zero: 0x00 (build id), 0x04 and 0x08 (change numbers), 0x10 (soft-reset control, which is write-only), 0x18 (PCIe link state). Every unmapped or unaligned offset also reads zero.
- R4: Offset 0x14 (DDR health) reads 0x00000005: bit 0 is locked, bit 2 is calibrated, and all other bits are 0.
- R5: Offset 0x30 (clock synthesiser) reads as follows. Bits 31:24 hold 1 (second divider). Bits 23:16 hold 1 (multiplier). Bits 15:8 hold `strap_ref_mhz` as sampled in the request cycle. Bits 7:0 hold 1 (first divider).
- R6: Offset 0x34 (build options) reads 0x0000000E: bits 1 to 3 mark three PCIe ports enabled, and bit 0 (coherence unit) is 0.
- R7: Offset 0x38 (DDR configuration) holds the RAM size in GiB in bits 3:0. That size is `strap_ram_gib`, saturated to 15. Bits 15:4 read as ones and bits 31:16 as zero.
- R8: A 4-byte write to offset 0x10 with bit 4 set drives `sys_reset_req` high for exactly the cycle after acceptance. With bit 4 clear, no request is raised.
- R9: Writes to the status and configuration offsets do not change what they read back.
- R10: Address bits above bit 15 are ignored for both reads and writes.
- R11: The response to a write carries zero data.
- R12: During and just after reset, `rsp_valid`, `rsp_rdata` and `sys_reset_req` are zero. `rsp_rdata` is zero whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (low 16 bits decoded) |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| strap_ref_mhz | input | 8 | Timer reference frequency in MHz |
| strap_ram_gib | input | 8 | Installed RAM in GiB |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Two functions can coincide in one cycle: the reset pulse of a soft-reset write and the response channel. First, the write's own zero-data response shares a cycle with its reset pulse. Second, back-to-back requests issued without idle cycles let a pulse overlap the acceptance of the following read. The bench issues these pairs back to back, including two successive reset writes and one reset write with a narrow size. Every cycle, a behavioural model predicts `rsp_valid`, `rsp_rdata` and `sys_reset_req` together, and the bench judges all three against the model.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned OFS_W = 16;

  localparam logic [OFS_W-1:0] OFS_BUILD_ID  = 16'h0000;
  localparam logic [OFS_W-1:0] OFS_CHG_CORE  = 16'h0004;
  localparam logic [OFS_W-1:0] OFS_CHG_WRAP  = 16'h0008;
  localparam logic [OFS_W-1:0] OFS_SOFTRST   = 16'h0010;
  localparam logic [OFS_W-1:0] OFS_DDR_STAT  = 16'h0014;
  localparam logic [OFS_W-1:0] OFS_LINK_STAT = 16'h0018;
  localparam logic [OFS_W-1:0] OFS_CLK_SYN   = 16'h0030;
  localparam logic [OFS_W-1:0] OFS_BUILD_OPT = 16'h0034;
  localparam logic [OFS_W-1:0] OFS_DDR_CFG   = 16'h0038;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_SOFTRST,
    SEL_DDR_STAT,
    SEL_CLK_SYN,
    SEL_BUILD_OPT,
    SEL_DDR_CFG
  } reg_sel_e;

  // Mask with one bit per enabled PCIe port, starting at bit 1.
  function automatic logic [31:0] port_mask(input int unsigned nports);
    logic [31:0] m;
    m = '0;
    for (int unsigned p = 0; p < nports; p++) m[p+1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned FULL_SIZE = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output reg_sel_e          sel,
  output logic              full_word
);

  logic [OFS_W-1:0] ofs;
  assign ofs       = addr[OFS_W-1:0];
  assign full_word = (size == SIZE_W'(FULL_SIZE));

  always_comb begin
    unique case (ofs)
      OFS_BUILD_ID, OFS_CHG_CORE,
      OFS_CHG_WRAP, OFS_LINK_STAT: sel = SEL_ZERO;
      OFS_SOFTRST:                 sel = SEL_SOFTRST;
      OFS_DDR_STAT:                sel = SEL_DDR_STAT;
      OFS_CLK_SYN:                 sel = SEL_CLK_SYN;
      OFS_BUILD_OPT:               sel = SEL_BUILD_OPT;
      OFS_DDR_CFG:                 sel = SEL_DDR_CFG;
      default:                     sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MHZ_W    = 8,
  parameter int unsigned RAM_W    = 8,
  parameter int unsigned NUM_PCIE = 3,
  parameter int unsigned GIB_W    = 4,
  parameter int unsigned SPEED_W  = 12
) (
  input  reg_sel_e          sel,
  input  logic [MHZ_W-1:0]  ref_mhz,
  input  logic [RAM_W-1:0]  ram_gib,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned LANE_W    = 8;
  localparam int unsigned LANES     = DATA_W / LANE_W;
  localparam int unsigned MHZ_LANE  = 1;
  localparam logic [RAM_W-1:0] GIB_MAX = RAM_W'((1 << GIB_W) - 1);
  localparam logic [DATA_W-1:0] DDR_OK_WORD = DATA_W'(32'h5);
  localparam logic [DATA_W-1:0] BUILD_WORD  = DATA_W'(port_mask(NUM_PCIE));
  localparam logic [DATA_W-1:0] SPEED_ONES  =
    DATA_W'(((64'd1 << SPEED_W) - 64'd1) << GIB_W);

  logic [DATA_W-1:0] syn_word;
  logic [GIB_W-1:0]  gib_sat;

  // One byte lane per synthesiser field: the reference lane carries the
  // strap, every other lane (dividers, multiplier) reads as one.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == MHZ_LANE) begin : g_mhz
      assign syn_word[l*LANE_W +: LANE_W] = LANE_W'(ref_mhz);
    end else begin : g_one
      assign syn_word[l*LANE_W +: LANE_W] = LANE_W'(1);
    end
  end

  assign gib_sat = (ram_gib > GIB_MAX) ? GIB_MAX[GIB_W-1:0] : ram_gib[GIB_W-1:0];

  always_comb begin
    unique case (sel)
      SEL_DDR_STAT:  rdata = DDR_OK_WORD;
      SEL_CLK_SYN:   rdata = syn_word;
      SEL_BUILD_OPT: rdata = BUILD_WORD;
      SEL_DDR_CFG:   rdata = SPEED_ONES | DATA_W'(gib_sat);
      default:       rdata = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_rstctl.sv
module sysctl_rstctl #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RST_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              reset_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_pulse <= 1'b0;
    else        reset_pulse <= ctl_wr && wdata[RST_BIT];
  end

  // R8: a pulse never lasts two cycles unless two commands came back to back
  assert_pulse_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |-> $past(ctl_wr));

endmodule

// File: rtl/board_sysctl.sv
module board_sysctl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned MHZ_W     = 8,
  parameter int unsigned RAM_W     = 8,
  parameter int unsigned NUM_PCIE  = 3,
  parameter int unsigned RST_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [MHZ_W-1:0]  strap_ref_mhz,
  input  logic [RAM_W-1:0]  strap_ram_gib,
  output logic              sys_reset_req
);

  localparam int unsigned FULL_SIZE = DATA_W / 8;

  reg_sel_e          sel;
  logic              full_word;
  logic              accepted;
  logic              ctl_wr;
  logic [DATA_W-1:0] rd_word;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FULL_SIZE(FULL_SIZE)
  ) u_decode (
    .addr(req_addr), .size(req_size), .sel(sel), .full_word(full_word)
  );

  sysctl_rdmux #(
    .DATA_W(DATA_W), .MHZ_W(MHZ_W), .RAM_W(RAM_W), .NUM_PCIE(NUM_PCIE)
  ) u_rdmux (
    .sel(sel), .ref_mhz(strap_ref_mhz), .ram_gib(strap_ram_gib), .rdata(rd_word)
  );

  assign accepted = req_valid && req_ready;
  assign ctl_wr   = accepted && req_write && full_word && (sel == SEL_SOFTRST);

  sysctl_rstctl #(
    .DATA_W(DATA_W), .RST_BIT(RST_BIT)
  ) u_rstctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(req_wdata),
    .reset_pulse(sys_reset_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accepted;
      rsp_rdata <= (accepted && !req_write && full_word) ? rd_word : '0;
    end
  end

  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> rsp_valid);
  assert_rsp_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !accepted |=> !rsp_valid);
  assert_narrow_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_size != SIZE_W'(FULL_SIZE)) |=> (rsp_rdata == '0 && !sys_reset_req));
  assert_ddr_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !req_write && full_word && req_addr[15:0] == OFS_DDR_STAT)
      |=> rsp_rdata == DATA_W'(32'h5));
  assert_wr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && req_write) |=> rsp_rdata == '0);
  assert_pulse_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(accepted && req_write));
  assert_idle_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_rdata == '0);

endmodule

// File: tb/board_sysctl_tb_top.sv
module board_sysctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  strap_ref_mhz = 8'd50;
  logic [7:0]  strap_ram_gib = 8'd1;
  logic        sys_reset_req;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  string cur_tag = "R1";
  string exp_tag = "R1";
  logic        exp_ready = 1'b0;
  logic        exp_valid = 1'b0;
  logic [31:0] exp_rdata = '0;
  logic        exp_rst = 1'b0;

  always #2 clk = ~clk;

  board_sysctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .strap_ref_mhz(strap_ref_mhz), .strap_ram_gib(strap_ram_gib),
    .sys_reset_req(sys_reset_req)
  );

  function automatic logic [31:0] model_read(logic [31:0] a, logic [3:0] sz,
                                             logic [7:0] mhz, logic [7:0] gib);
    int ofs = int'(a & 32'hFFFF);
    int g = (gib > 15) ? 15 : int'(gib);
    if (sz != 4) return 32'h0;
    case (ofs)
      'h14: return 32'h5;
      'h30: return (32'd1 << 24) | (32'd1 << 16) | (32'(mhz) << 8) | 32'd1;
      'h34: return 32'hE;
      'h38: return 32'hFFF0 | 32'(g);
      default: return 32'h0;
    endcase
  endfunction

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_ready <= 1'b0; exp_valid <= 1'b0; exp_rdata <= '0; exp_rst <= 1'b0;
    end else begin
      exp_ready <= 1'b1;
      exp_valid <= req_valid && exp_ready;
      exp_rdata <= (req_valid && exp_ready && !req_write)
                   ? model_read(req_addr, req_size, strap_ref_mhz, strap_ram_gib) : '0;
      exp_rst   <= req_valid && exp_ready && req_write && req_size == 4 &&
                   req_addr[15:0] == 16'h0010 && req_wdata[4];
      exp_tag   <= cur_tag;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check("R1", "req_ready", 32'(req_ready), 32'(exp_ready));
      check(exp_tag, "rsp_valid", 32'(rsp_valid), 32'(exp_valid));
      check(exp_tag, "rsp_rdata", rsp_rdata, exp_rdata);
      check(exp_tag, "sys_reset_req", 32'(sys_reset_req), 32'(exp_rst));
    end
  end

  task automatic txn(string tag, bit wr, logic [31:0] a, logic [3:0] sz, logic [31:0] d);
    @(negedge clk);
    cur_tag = tag; req_valid = 1'b1; req_write = wr;
    req_addr = a; req_size = sz; req_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cur_tag = "R1"; req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
    check("R12", "rsp_rdata in reset", rsp_rdata, 32'h0);
    check("R12", "sys_reset_req in reset", 32'(sys_reset_req), 32'h0);
    rst_n = 1'b1;
    model_on = 1'b1;
    idle(3);
    // R3: zero words and unmapped space
    txn("R3", 0, 32'h00, 4, 0); txn("R3", 0, 32'h04, 4, 0);
    txn("R3", 0, 32'h08, 4, 0); txn("R3", 0, 32'h10, 4, 0);
    txn("R3", 0, 32'h18, 4, 0); txn("R3", 0, 32'h48, 4, 0);
    txn("R3", 0, 32'hFFC, 4, 0); txn("R3", 0, 32'h15, 4, 0);
    idle(1);
    txn("R4", 0, 32'h14, 4, 0);
    txn("R6", 0, 32'h34, 4, 0);
    // R5: several reference frequencies
    strap_ref_mhz = 8'd0;   txn("R5", 0, 32'h30, 4, 0);
    @(negedge clk) strap_ref_mhz = 8'd255; cur_tag = "R5"; // request still held
    txn("R5", 0, 32'h30, 4, 0);
    idle(1); strap_ref_mhz = 8'd100; txn("R5", 0, 32'h30, 4, 0);
    // R7: RAM size, including saturation
    idle(1); strap_ram_gib = 8'd2;   txn("R7", 0, 32'h38, 4, 0);
    idle(1); strap_ram_gib = 8'd15;  txn("R7", 0, 32'h38, 4, 0);
    idle(1); strap_ram_gib = 8'd16;  txn("R7", 0, 32'h38, 4, 0);
    idle(1); strap_ram_gib = 8'd200; txn("R7", 0, 32'h38, 4, 0);
    // R2: narrow and wide accesses
    txn("R2", 0, 32'h14, 1, 0); txn("R2", 0, 32'h34, 2, 0);
    txn("R2", 0, 32'h30, 8, 0); txn("R2", 1, 32'h10, 2, 32'h10);
    txn("R2", 1, 32'h10, 8, 32'hFFFF_FFFF);
    idle(2);
    // R8: reset pulse, bit clear, back to back, overlap with read
    txn("R8", 1, 32'h10, 4, 32'h10);
    idle(2);
    txn("R8", 1, 32'h10, 4, 32'hFFFF_FFEF);
    txn("R8", 1, 32'h10, 4, 32'hFFFF_FFFF);
    txn("R8", 1, 32'h10, 4, 32'h10);
    txn("R8", 0, 32'h14, 4, 0);
    idle(2);
    // R9: writes to read-only words leave them intact
    txn("R9", 1, 32'h14, 4, 32'h0); txn("R9", 0, 32'h14, 4, 0);
    txn("R9", 1, 32'h34, 4, 32'hFFFF_FFFF); txn("R9", 0, 32'h34, 4, 0);
    txn("R9", 1, 32'h38, 4, 32'h0); txn("R9", 0, 32'h38, 4, 0);
    txn("R9", 1, 32'h30, 4, 32'h0); txn("R9", 0, 32'h30, 4, 0);
    // R10: upper address bits ignored
    txn("R10", 0, 32'hABCD_0014, 4, 0);
    txn("R10", 0, 32'h1234_0034, 4, 0);
    txn("R10", 1, 32'h8001_0010, 4, 32'h10);
    // R11: write response data
    txn("R11", 1, 32'h00, 4, 32'hDEAD_BEEF);
    txn("R11", 1, 32'h200, 4, 32'h1234_5678);
    idle(4);
    model_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule